// File: doc/BRIEF.md
# Multi-width aliased register file

This block holds eight 32-bit general registers in a single storage array and lets each one be seen at three widths. A full longword view addresses the whole register. A halfword view picks either the upper or the lower 16 bits. A byte view picks either byte of the lower half. Because every view lands in the same storage, a narrow write changes only its own field and leaves the other bits of the register alone. A narrow read returns its field zero-extended to 32 bits.

There are two read ports and one write port. Each port carries its own size selector and a 4-bit register specifier. Register 7 doubles as the stack pointer. A dedicated port gives a 32-bit read of it and a separate 32-bit write, so stack and exception sequencing can reach it without going through the general ports.

A third read path serves address indexing. It accepts only the longword, lower-halfword and low-byte views and zero-extends the result. A request for the upper halfword or the high byte raises an error flag. Reads are combinational and writes land on the rising clock edge.

Top module: `gpr_bank`

## Requirements
- R1: A synchronous reset (`rst` high at a rising edge) clears all eight registers to zero, so after it every read view and the stack-pointer output return 0.
- R2: Size code 2'b10 selects the 32-bit view. The register is given by specifier bits [2:0], and bit 3 is ignored. A write replaces all 32 bits and a read returns all 32 bits.
- R3: Size code 2'b01 selects a 16-bit view. Specifier codes 0-7 pick bits [15:0] of registers 0-7, and codes 8-15 pick bits [31:16] of registers 0-7. A read returns the field with bits [31:16] zero.
- R4: Size code 2'b00 selects a byte view. Specifier codes 0-7 pick bits [15:8] of registers 0-7, and codes 8-15 pick bits [7:0] of registers 0-7. A read returns the byte with bits [31:8] zero.
- R5: A 16-bit or 8-bit write changes only the addressed field, and every other bit of that register keeps its previous value.
- R6: Reads are combinational with no bypass. A read in the same cycle as a write to the same register returns the old value, and the new value is visible from the cycle after the rising edge.
- R7: The stack-pointer output always shows register 7. With `sp_we` high, `sp_wdata` is written into all 32 bits of register 7 at the rising edge, and this is visible through the general read ports too.
- R8: If `sp_we` is high in the same cycle as a general write to register 7 of any width, register 7 afterwards equals `sp_wdata` exactly.
- R9: The index path returns the 32-bit view for size 2'b10, the lower half for size 2'b01 with codes 0-7, and the low byte for size 2'b00 with codes 8-15, all zero-extended. Any other size/code pair (upper half, high byte, or size 2'b11) sets `ix_illegal` and drives `ix_data` to 0.
- R10: Size code 2'b11 is reserved. A general write with it changes no register, and a read port given it returns 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| ra_size | input | 2 | Read port A size code |
| ra_sel | input | 4 | Read port A register specifier |
| ra_data | output | 32 | Read port A data, zero-extended |
| rb_size | input | 2 | Read port B size code |
| rb_sel | input | 4 | Read port B register specifier |
| rb_data | output | 32 | Read port B data, zero-extended |
| w_en | input | 1 | General write enable |
| w_size | input | 2 | General write size code |
| w_sel | input | 4 | General write register specifier |
| w_data | input | 32 | General write data, field taken from the low bits |
| sp_we | input | 1 | Stack-pointer write enable |
| sp_wdata | input | 32 | Stack-pointer write data |
| sp_rdata | output | 32 | Current value of register 7 |
| ix_size | input | 2 | Index path size code |
| ix_sel | input | 4 | Index path register specifier |
| ix_data | output | 32 | Index value, zero-extended |
| ix_illegal | output | 1 | Index request names a view that cannot index |

## Verification
Every read output (both ports, the stack-pointer output and the index path with its error flag) is due in the same cycle as its selector inputs, with no register on the way. A write is due one rising edge later.

The bench drives inputs just after a falling edge and compares all outputs against a behavioural model in the middle of the low phase, before the edge that commits that cycle's writes. The model is updated only after the rising edge. As a result, a same-cycle read of a register being written must show the old contents, and the following cycle must show the merged result.

// File: rtl/gpr_bank.sv
module gpr_bank #(
  parameter int NREG = 8,
  parameter int DW   = 32
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [1:0]    ra_size,
  input  logic [3:0]    ra_sel,
  output logic [DW-1:0] ra_data,
  input  logic [1:0]    rb_size,
  input  logic [3:0]    rb_sel,
  output logic [DW-1:0] rb_data,
  input  logic          w_en,
  input  logic [1:0]    w_size,
  input  logic [3:0]    w_sel,
  input  logic [DW-1:0] w_data,
  input  logic          sp_we,
  input  logic [DW-1:0] sp_wdata,
  output logic [DW-1:0] sp_rdata,
  input  logic [1:0]    ix_size,
  input  logic [3:0]    ix_sel,
  output logic [DW-1:0] ix_data,
  output logic          ix_illegal
);
  localparam int AW = $clog2(NREG);
  localparam int HW = DW / 2;
  localparam int BW = DW / 4;
  localparam int SP = NREG - 1;
  localparam logic [1:0] SZ_L = 2'b10;
  localparam logic [1:0] SZ_W = 2'b01;
  localparam logic [1:0] SZ_B = 2'b00;

  logic [DW-1:0] rf [NREG];

  function automatic logic [DW-1:0] pick(input logic [DW-1:0] w,
                                         input logic [1:0] sz, input logic hi);
    case (sz)
      SZ_L:    pick = w;
      SZ_W:    pick = hi ? {{HW{1'b0}}, w[DW-1:HW]} : {{HW{1'b0}}, w[HW-1:0]};
      SZ_B:    pick = hi ? {{(DW-BW){1'b0}}, w[BW-1:0]}
                         : {{(DW-BW){1'b0}}, w[HW-1:BW]};
      default: pick = '0;
    endcase
  endfunction

  function automatic logic [DW-1:0] merge(input logic [DW-1:0] old,
                                          input logic [DW-1:0] nw,
                                          input logic [1:0] sz, input logic hi);
    case (sz)
      SZ_L:    merge = nw;
      SZ_W:    merge = hi ? {nw[HW-1:0], old[HW-1:0]} : {old[DW-1:HW], nw[HW-1:0]};
      SZ_B:    merge = hi ? {old[DW-1:BW], nw[BW-1:0]}
                          : {old[DW-1:HW], nw[BW-1:0], old[BW-1:0]};
      default: merge = old;
    endcase
  endfunction

  logic [AW-1:0] w_reg;
  logic          ix_ok;

  assign w_reg    = w_sel[AW-1:0];
  assign ra_data  = pick(rf[ra_sel[AW-1:0]], ra_size, ra_sel[3]);
  assign rb_data  = pick(rf[rb_sel[AW-1:0]], rb_size, rb_sel[3]);
  assign sp_rdata = rf[SP];

  assign ix_ok = (ix_size == SZ_L) ||
                 (ix_size == SZ_W && !ix_sel[3]) ||
                 (ix_size == SZ_B &&  ix_sel[3]);
  assign ix_illegal = !ix_ok;
  assign ix_data    = ix_ok ? pick(rf[ix_sel[AW-1:0]], ix_size, ix_sel[3]) : '0;

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < NREG; i++) rf[i] <= '0;
    end else begin
      if (w_en) rf[w_reg] <= merge(rf[w_reg], w_data, w_size, w_sel[3]);
      if (sp_we) rf[SP] <= sp_wdata;
    end
  end
endmodule

// File: rtl/gpr_bank_chk.sv
module gpr_bank_chk (
  input logic        clk,
  input logic        rst,
  input logic [1:0]  ra_size,
  input logic [31:0] ra_data,
  input logic [31:0] rb_data,
  input logic        w_en,
  input logic [1:0]  w_size,
  input logic [2:0]  w_reg,
  input logic [31:0] w_data,
  input logic        sp_we,
  input logic [31:0] sp_wdata,
  input logic [31:0] sp_rdata,
  input logic [1:0]  ix_size,
  input logic        ix_hi,
  input logic [31:0] ix_data,
  input logic        ix_illegal
);
  assert_reset_clear_R1: assert property (@(posedge clk)
    rst |=> (ra_data == 32'h0 && rb_data == 32'h0 && sp_rdata == 32'h0));

  assert_long_write_R2: assert property (@(posedge clk) disable iff (rst)
    (w_en && w_size == 2'b10 && w_reg == 3'd7 && !sp_we) |=> sp_rdata == $past(w_data));

  assert_half_zext_R3: assert property (@(posedge clk) disable iff (rst)
    (ra_size == 2'b01) |-> ra_data[31:16] == 16'h0);

  assert_byte_zext_R4: assert property (@(posedge clk) disable iff (rst)
    (ra_size == 2'b00) |-> ra_data[31:8] == 24'h0);

  assert_sp_wins_R8: assert property (@(posedge clk) disable iff (rst)
    sp_we |=> sp_rdata == $past(sp_wdata));

  assert_idx_flag_R9: assert property (@(posedge clk) disable iff (rst)
    ((ix_size == 2'b01 && ix_hi) || (ix_size == 2'b00 && !ix_hi) || ix_size == 2'b11)
      |-> (ix_illegal && ix_data == 32'h0));

  assert_reserved_write_R10: assert property (@(posedge clk) disable iff (rst)
    (w_en && w_size == 2'b11 && !sp_we) |=> $stable(sp_rdata));
endmodule

bind gpr_bank gpr_bank_chk u_chk (
  .clk(clk), .rst(rst), .ra_size(ra_size), .ra_data(ra_data), .rb_data(rb_data),
  .w_en(w_en), .w_size(w_size), .w_reg(w_sel[2:0]), .w_data(w_data),
  .sp_we(sp_we), .sp_wdata(sp_wdata), .sp_rdata(sp_rdata),
  .ix_size(ix_size), .ix_hi(ix_sel[3]), .ix_data(ix_data), .ix_illegal(ix_illegal)
);

// File: tb/tb_gpr_bank.sv
module tb_gpr_bank;
  logic clk = 1'b0;
  logic rst;
  logic [1:0] ra_size, rb_size, w_size, ix_size;
  logic [3:0] ra_sel, rb_sel, w_sel, ix_sel;
  logic w_en, sp_we;
  logic [31:0] w_data, sp_wdata;
  logic [31:0] ra_data, rb_data, sp_rdata, ix_data;
  logic ix_illegal;

  int checks = 0;
  int fails = 0;
  bit done = 0;
  logic [31:0] model [8];

  always #10 clk = ~clk;

  gpr_bank dut (
    .clk(clk), .rst(rst),
    .ra_size(ra_size), .ra_sel(ra_sel), .ra_data(ra_data),
    .rb_size(rb_size), .rb_sel(rb_sel), .rb_data(rb_data),
    .w_en(w_en), .w_size(w_size), .w_sel(w_sel), .w_data(w_data),
    .sp_we(sp_we), .sp_wdata(sp_wdata), .sp_rdata(sp_rdata),
    .ix_size(ix_size), .ix_sel(ix_sel), .ix_data(ix_data), .ix_illegal(ix_illegal)
  );

  function automatic logic [31:0] view(input logic [1:0] sz, input logic [3:0] c);
    int r = int'(c) % 8;
    int v = int'(model[r]);
    case (sz)
      2'b10: return model[r];
      2'b01: return (c >= 8) ? 32'((v >>> 16) & 32'hFFFF) : 32'(v & 32'hFFFF);
      2'b00: return (c >= 8) ? 32'(v & 32'hFF) : 32'((v >>> 8) & 32'hFF);
      default: return 32'h0;
    endcase
  endfunction

  function automatic bit ix_bad(input logic [1:0] sz, input logic [3:0] c);
    if (sz == 2'b10) return 0;
    if (sz == 2'b01 && c < 8) return 0;
    if (sz == 2'b00 && c >= 8) return 0;
    return 1;
  endfunction

  task automatic chk(input string tag, input string nm,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s act=%h exp=%h", tag, nm, act, exp);
    end
  endtask

  task automatic cyc(input string tag);
    logic [31:0] m;
    #5;
    chk(tag, "ra_data", ra_data, view(ra_size, ra_sel));
    chk(tag, "rb_data", rb_data, view(rb_size, rb_sel));
    chk(tag, "sp_rdata", sp_rdata, model[7]);
    chk(tag, "ix_illegal", {31'h0, ix_illegal}, {31'h0, ix_bad(ix_size, ix_sel)});
    chk(tag, "ix_data", ix_data, ix_bad(ix_size, ix_sel) ? 32'h0 : view(ix_size, ix_sel));
    @(posedge clk);
    #1;
    if (rst) begin
      for (int i = 0; i < 8; i++) model[i] = 32'h0;
    end else begin
      if (w_en) begin
        m = model[w_sel % 8];
        case (w_size)
          2'b10: m = w_data;
          2'b01: if (w_sel >= 8) m = (m & 32'h0000FFFF) | (w_data << 16);
                 else m = (m & 32'hFFFF0000) | (w_data & 32'hFFFF);
          2'b00: if (w_sel >= 8) m = (m & 32'hFFFFFF00) | (w_data & 32'hFF);
                 else m = (m & 32'hFFFF00FF) | ((w_data & 32'hFF) << 8);
          default: ;
        endcase
        model[w_sel % 8] = m;
      end
      if (sp_we) model[7] = sp_wdata;
    end
    @(negedge clk);
  endtask

  task automatic quiet();
    w_en = 0; sp_we = 0; w_size = 2'b10; w_sel = 0; w_data = 0; sp_wdata = 0;
  endtask

  task automatic wr(input logic [1:0] sz, input logic [3:0] c, input logic [31:0] d);
    w_en = 1; w_size = sz; w_sel = c; w_data = d;
  endtask

  initial begin
    #(20 * 200000);
    if (!done) begin
      fails++;
      checks++;
      $display("FAIL watchdog act=timeout exp=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 8; i++) model[i] = 32'h0;
    rst = 1; quiet();
    ra_size = 2'b10; ra_sel = 0; rb_size = 2'b01; rb_sel = 9;
    ix_size = 2'b10; ix_sel = 3;
    @(negedge clk);
    cyc("R1"); cyc("R1");
    rst = 0;
    for (int c = 0; c < 16; c++) begin
      ra_sel = 4'(c); rb_sel = 4'(15 - c); rb_size = 2'(c % 3);
      cyc("R1");
    end

    // full-width writes, same-cycle read sees old value
    ra_size = 2'b10; rb_size = 2'b10;
    for (int i = 0; i < 8; i++) begin
      wr(2'b10, 4'(i), 32'h01234567 ^ (32'h11111111 * i));
      ra_sel = 4'(i);
      cyc("R6");
    end
    quiet();
    for (int i = 0; i < 8; i++) begin
      ra_sel = 4'(i); rb_sel = 4'(8 + (i + 1) % 8);
      cyc("R2");
    end

    ra_size = 2'b01; rb_size = 2'b01;
    for (int c = 0; c < 16; c++) begin
      ra_sel = 4'(c); rb_sel = 4'(15 - c);
      cyc("R3");
    end
    ra_size = 2'b00; rb_size = 2'b00;
    for (int c = 0; c < 16; c++) begin
      ra_sel = 4'(c); rb_sel = 4'(15 - c);
      cyc("R4");
    end

    // partial writes keep other bits
    ra_size = 2'b10; ra_sel = 3; rb_size = 2'b10; rb_sel = 5;
    wr(2'b01, 4'd11, 32'hFFFFBEEF); cyc("R5");
    wr(2'b00, 4'd11, 32'hFFFFFF5A); cyc("R5");
    wr(2'b00, 4'd3,  32'hFFFFFFC3); cyc("R5");
    wr(2'b01, 4'd5,  32'hAAAA1234); cyc("R5");
    wr(2'b00, 4'd13, 32'h00000077); cyc("R5");
    quiet(); cyc("R5"); cyc("R5");

    // stack pointer port
    ra_sel = 7; rb_size = 2'b01; rb_sel = 15;
    sp_we = 1; sp_wdata = 32'hCAFEF00D; cyc("R7");
    quiet(); cyc("R7"); cyc("R7");

    // simultaneous general and stack-pointer write
    wr(2'b10, 4'd7, 32'hDEAD0000); sp_we = 1; sp_wdata = 32'h00C0FFEE; cyc("R8");
    quiet(); cyc("R8");
    wr(2'b00, 4'd15, 32'h000000AB); sp_we = 1; sp_wdata = 32'h13572468; cyc("R8");
    quiet(); cyc("R8");
    wr(2'b01, 4'd15, 32'h00009999); sp_we = 1; sp_wdata = 32'h80000001; cyc("R8");
    quiet(); cyc("R8");

    // index path
    for (int s = 0; s < 4; s++)
      for (int c = 0; c < 16; c++) begin
        ix_size = 2'(s); ix_sel = 4'(c);
        cyc("R9");
      end

    // reserved size code
    ra_size = 2'b10; ra_sel = 2;
    wr(2'b11, 4'd2, 32'hFFFFFFFF); cyc("R10");
    wr(2'b11, 4'd15, 32'hFFFFFFFF); cyc("R10");
    quiet();
    ra_size = 2'b11; cyc("R10");
    ra_size = 2'b10; ra_sel = 2; cyc("R10");
    ra_sel = 7; cyc("R10");

    // mixed traffic
    for (int n = 0; n < 3000; n++) begin
      w_en = 1'($urandom); w_size = 2'($urandom); w_sel = 4'($urandom);
      w_data = $urandom; sp_we = ($urandom % 6) == 0; sp_wdata = $urandom;
      ra_size = 2'($urandom); ra_sel = 4'($urandom);
      rb_size = 2'($urandom); rb_sel = 4'($urandom);
      ix_size = 2'($urandom); ix_sel = 4'($urandom);
      cyc("MIX");
    end

    // reset after traffic
    quiet(); rst = 1; cyc("R1"); rst = 0;
    for (int c = 0; c < 16; c++) begin
      ra_size = 2'(c % 3); ra_sel = 4'(c); rb_size = 2'b10; rb_sel = 4'(c);
      ix_size = 2'b10; ix_sel = 4'(c);
      cyc("R1");
    end

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule